// File: doc/BRIEF.md
# Mixed-Length Code Block Unpacker

This block takes one 256-bit code block whose low 32 bits are a header for the mixed-length format, and turns the payload into a stream of instructions. The payload above the header holds fourteen 16-bit extents. The header gives each extent a two-bit tag, and the tag alone decides where instructions start and end. The opcode bits are never inspected.

A block is written through the load port whenever `load_ready` is high. The unpacker then walks the extents from the lowest address upward. It presents one instruction at a time on a valid/ready output. Each instruction carries its width in extents, a flag that marks it as short, and the index of its first extent. A short instruction is 17 bits wide: its top bit comes from the low bit of its tag. A long instruction spans 2 to 6 extents and is left-justified in a 96-bit field. When every extent has been consumed and the last instruction has been accepted, `done` rises. `err` reports a malformed block.

Top module: `xbu_unpacker`

## Requirements
- R1: After reset `ins_valid`, `done` and `err` are 0 and `load_ready` is 1.
- R2: The header's top four bits [31:28] must equal 4'b1111. Any other value sets `err` and `done` and produces no instruction.
- R3: Extent k (payload bits [32+16k +: 16]) with tag 2'b00 (header bits [2k+1:2k]) is emitted as short with value {1'b0, extent} in `ins_data[16:0]`, upper bits zero, `ins_len` 1 and `ins_off` k.
- R4: An extent tagged 2'b01 is emitted as short with value {1'b1, extent}, `ins_len` 1.
- R5: An extent tagged 2'b10 and followed by n consecutive 2'b11 extents (1 ≤ n ≤ 5) is emitted as one long instruction. It has `ins_len` n+1 and `ins_off` equal to the 2'b10 extent's index. The first extent sits in `ins_data[95:80]`, the following extents descend in order, and the unused low bits are zero.
- R6: A long instruction is capped at 6 extents. Any 2'b11 extents beyond the cap produce no output.
- R7: 2'b11 extents that do not continue a long instruction produce no output.
- R8: A 2'b10 extent that is not followed by a 2'b11 extent (including one in the last position) produces no output and sets `err`. Scanning continues with the next extent.
- R9: While `ins_valid` is 1 and `ins_ready` is 0, all output fields hold their values.
- R10: Instructions leave in increasing extent order. `done` rises only after all fourteen extents are consumed and the last instruction is accepted. `ins_valid` is never high together with `done`, and `load_ready` is 1 whenever `done` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Load strobe for a new block |
| load_data | input | 256 | Block: header in [31:0], extents above |
| load_ready | output | 1 | Unpacker can take a block |
| ins_valid | output | 1 | Instruction present |
| ins_ready | input | 1 | Consumer takes the instruction |
| ins_data | output | 96 | Instruction bits (short right-aligned, long left-justified) |
| ins_short | output | 1 | Instruction is a 17-bit short form |
| ins_len | output | 3 | Width in extents (1 for short) |
| ins_off | output | 4 | Index of the first extent |
| done | output | 1 | Block fully unpacked |
| err | output | 1 | Malformed block seen |

## Verification
The following rules are checked on every clock: the output holds while it is stalled, the offsets increase within a block, short outputs have the correct shape, long lengths stay between 2 and 6, `done` never coincides with `ins_valid`, and the outputs are quiet after reset. Only the bench's scenarios can show that the instruction sequence is correct. That covers tag decoding, continuation counting and the cap, silent skipping of orphan continuations, lone-head errors and rejection of a wrong form code. The bench checks these against an arithmetic model over crafted blocks and several hundred pseudo-random blocks, with a randomly throttled `ins_ready`.

// File: rtl/xbu_pkg.sv
package xbu_pkg;

    localparam int PFX_W  = 2;
    localparam int FORM_W = 4;
    localparam logic [FORM_W-1:0] FORM_MIXED = 4'b1111;

    typedef enum logic [PFX_W-1:0] {
        PFX_SHORT0 = 2'b00,
        PFX_SHORT1 = 2'b01,
        PFX_HEAD   = 2'b10,
        PFX_CONT   = 2'b11
    } pfx_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

endpackage

// File: rtl/xbu_hdr_split.sv
module xbu_hdr_split
    import xbu_pkg::*;
#(
    parameter int BLOCK_W = 256,
    parameter int EXT_W   = 16,
    parameter int HDR_W   = 32,
    parameter int NUM_EXT = 14
) (
    input  logic [BLOCK_W-1:0]                blk,
    output logic                              form_ok,
    output logic [NUM_EXT-1:0][PFX_W-1:0]     pfx,
    output logic [NUM_EXT-1:0][EXT_W-1:0]     ext
);

    // Form code occupies the top bits of the header word.
    assign form_ok = (blk[HDR_W-1 -: FORM_W] == FORM_MIXED);

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_lane
        assign pfx[g] = blk[g*PFX_W +: PFX_W];
        assign ext[g] = blk[HDR_W + g*EXT_W +: EXT_W];
    end

endmodule

// File: rtl/xbu_scan.sv
module xbu_scan
    import xbu_pkg::*;
#(
    parameter int EXT_W   = 16,
    parameter int NUM_EXT = 14,
    parameter int MAX_EXT = 6,
    parameter int IDX_W   = 4,
    parameter int LEN_W   = 3,
    parameter int DATA_W  = 96
) (
    input  logic [NUM_EXT-1:0][PFX_W-1:0] pfx,
    input  logic [NUM_EXT-1:0][EXT_W-1:0] ext,
    input  logic [IDX_W-1:0]              idx,
    output logic                          emit,
    output logic                          is_short,
    output logic [LEN_W-1:0]              len,
    output logic [DATA_W-1:0]             data,
    output logic [IDX_W-1:0]              adv,
    output logic                          lone
);

    localparam int SUM_W = $clog2(NUM_EXT + MAX_EXT + 1);

    pfx_e              cur;
    logic [LEN_W-1:0]  run;
    logic              go;
    logic [SUM_W-1:0]  pos;

    // Count continuation extents directly after the current one, up to the cap.
    always_comb begin
        cur = PFX_CONT;
        if (idx < IDX_W'(NUM_EXT)) cur = pfx_e'(pfx[idx]);
        run = '0;
        go  = 1'b1;
        pos = '0;
        for (int k = 1; k < MAX_EXT; k++) begin
            pos = SUM_W'(idx) + SUM_W'(k);
            if (go && (pos < SUM_W'(NUM_EXT)) && (pfx[pos[IDX_W-1:0]] == PFX_CONT))
                run = run + LEN_W'(1);
            else
                go = 1'b0;
        end
    end

    always_comb begin
        emit     = 1'b0;
        is_short = 1'b0;
        len      = '0;
        data     = '0;
        adv      = IDX_W'(1);
        lone     = 1'b0;
        case (cur)
            PFX_SHORT0, PFX_SHORT1: begin
                emit     = 1'b1;
                is_short = 1'b1;
                len      = LEN_W'(1);
                data     = DATA_W'({cur[0], ext[idx]});
            end
            PFX_HEAD: begin
                if (run == '0) begin
                    lone = 1'b1;
                end else begin
                    emit = 1'b1;
                    len  = run + LEN_W'(1);
                    adv  = IDX_W'(run) + IDX_W'(1);
                    for (int k = 0; k < MAX_EXT; k++) begin
                        if ((LEN_W'(k) <= run) &&
                            ((SUM_W'(idx) + SUM_W'(k)) < SUM_W'(NUM_EXT)))
                            data[DATA_W-1-k*EXT_W -: EXT_W] =
                                ext[IDX_W'(SUM_W'(idx) + SUM_W'(k))];
                    end
                end
            end
            default: begin
                // orphan continuation or pseudo-immediate space: skip
            end
        endcase
    end

endmodule

// File: rtl/xbu_out_reg.sv
module xbu_out_reg #(
    parameter int DATA_W = 96,
    parameter int LEN_W  = 3,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              emit,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_short,
    input  logic [LEN_W-1:0]  d_len,
    input  logic [IDX_W-1:0]  d_off,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data,
    output logic              q_short,
    output logic [LEN_W-1:0]  q_len,
    output logic [IDX_W-1:0]  q_off
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
            q_short <= 1'b0;
            q_len   <= '0;
            q_off   <= '0;
        end else if (take) begin
            q_valid <= emit;
            if (emit) begin
                q_data  <= d_data;
                q_short <= d_short;
                q_len   <= d_len;
                q_off   <= d_off;
            end
        end
    end

endmodule

// File: rtl/xbu_unpacker.sv
module xbu_unpacker
    import xbu_pkg::*;
#(
    parameter int BLOCK_W = 256,
    parameter int EXT_W   = 16,
    parameter int HDR_W   = 32,
    parameter int MAX_EXT = 6,
    localparam int NUM_EXT = (BLOCK_W - HDR_W) / EXT_W,
    localparam int IDX_W   = $clog2(NUM_EXT + 1),
    localparam int LEN_W   = $clog2(MAX_EXT + 1),
    localparam int DATA_W  = MAX_EXT * EXT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_valid,
    input  logic [BLOCK_W-1:0] load_data,
    output logic               load_ready,
    output logic               ins_valid,
    input  logic               ins_ready,
    output logic [DATA_W-1:0]  ins_data,
    output logic               ins_short,
    output logic [LEN_W-1:0]   ins_len,
    output logic [IDX_W-1:0]   ins_off,
    output logic               done,
    output logic               err
);

    state_e                          state;
    logic [BLOCK_W-1:0]              blk_q;
    logic [IDX_W-1:0]                idx;
    logic                            err_q;

    logic                            form_ok;
    logic [NUM_EXT-1:0][PFX_W-1:0]   pfx;
    logic [NUM_EXT-1:0][EXT_W-1:0]   ext;

    logic                            s_emit, s_short, s_lone;
    logic [LEN_W-1:0]                s_len;
    logic [DATA_W-1:0]               s_data;
    logic [IDX_W-1:0]                s_adv;

    logic                            step_en, finish_now, emit_ok;

    xbu_hdr_split #(
        .BLOCK_W(BLOCK_W), .EXT_W(EXT_W), .HDR_W(HDR_W), .NUM_EXT(NUM_EXT)
    ) u_split (
        .blk(blk_q), .form_ok(form_ok), .pfx(pfx), .ext(ext)
    );

    xbu_scan #(
        .EXT_W(EXT_W), .NUM_EXT(NUM_EXT), .MAX_EXT(MAX_EXT),
        .IDX_W(IDX_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
    ) u_scan (
        .pfx(pfx), .ext(ext), .idx(idx),
        .emit(s_emit), .is_short(s_short), .len(s_len),
        .data(s_data), .adv(s_adv), .lone(s_lone)
    );

    // A step happens when the output slot is empty or being drained.
    assign step_en    = (state == ST_SCAN) && (!ins_valid || ins_ready);
    assign finish_now = !form_ok || (idx >= IDX_W'(NUM_EXT));
    assign emit_ok    = s_emit && !finish_now;

    xbu_out_reg #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_out (
        .clk(clk), .rst(rst), .take(step_en), .emit(emit_ok),
        .d_data(s_data), .d_short(s_short), .d_len(s_len), .d_off(idx),
        .q_valid(ins_valid), .q_data(ins_data), .q_short(ins_short),
        .q_len(ins_len), .q_off(ins_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            blk_q <= '0;
            idx   <= '0;
            err_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_FIN: begin
                    if (load_valid) begin
                        blk_q <= load_data;
                        idx   <= '0;
                        err_q <= 1'b0;
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (step_en) begin
                        if (!form_ok) begin
                            err_q <= 1'b1;
                            state <= ST_FIN;
                        end else if (idx >= IDX_W'(NUM_EXT)) begin
                            state <= ST_FIN;
                        end else begin
                            idx <= idx + s_adv;
                            if (s_lone) err_q <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign load_ready = (state != ST_SCAN);
    assign done       = (state == ST_FIN);
    assign err        = err_q;

endmodule

// File: rtl/xbu_chk.sv
module xbu_chk #(
    parameter int DATA_W  = 96,
    parameter int EXT_W   = 16,
    parameter int LEN_W   = 3,
    parameter int IDX_W   = 4,
    parameter int MAX_EXT = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              load_ready,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [DATA_W-1:0] ins_data,
    input logic              ins_short,
    input logic [LEN_W-1:0]  ins_len,
    input logic [IDX_W-1:0]  ins_off,
    input logic              done,
    input logic              err
);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ins_valid && !done && !err && load_ready));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_data) &&
            $stable(ins_short) && $stable(ins_len) && $stable(ins_off)));

    a_r3_short_shape: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_short) |->
            (ins_len == LEN_W'(1) && ins_data[DATA_W-1:EXT_W+1] == '0));

    a_r5_long_len: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_short) |->
            (ins_len >= LEN_W'(2) && ins_len <= LEN_W'(MAX_EXT)));

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ins_valid && load_ready));

    a_r10_order: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_ready) |=> (!ins_valid || ins_off > $past(ins_off)));

endmodule

bind xbu_unpacker xbu_chk #(
    .DATA_W(DATA_W), .EXT_W(EXT_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .MAX_EXT(MAX_EXT)
) u_chk (
    .clk(clk), .rst(rst), .load_ready(load_ready), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_data(ins_data), .ins_short(ins_short),
    .ins_len(ins_len), .ins_off(ins_off), .done(done), .err(err)
);

// File: tb/xbu_unpacker_test.sv
module xbu_unpacker_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_valid = 1'b0;
    logic [255:0] load_data = '0;
    logic         load_ready;
    logic         ins_valid;
    logic         ins_ready = 1'b0;
    logic [95:0]  ins_data;
    logic         ins_short;
    logic [2:0]   ins_len;
    logic [3:0]   ins_off;
    logic         done;
    logic         err;

    always #5 clk = ~clk;

    xbu_unpacker uut (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_data(load_data),
        .load_ready(load_ready), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_data(ins_data), .ins_short(ins_short), .ins_len(ins_len),
        .ins_off(ins_off), .done(done), .err(err)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    logic [103:0] e_vec [14];
    string        e_tag [14];
    int           e_n;
    logic         e_err;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [103:0] act, input logic [103:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic model of the unpacking rules.
    task automatic model(input logic [255:0] b);
        int i;
        e_n = 0;
        e_err = 1'b0;
        if (b[31:28] != 4'hF) begin
            e_err = 1'b1;
            return;
        end
        i = 0;
        while (i < 14) begin
            logic [1:0] p;
            p = b[2*i +: 2];
            if (p == 2'b00 || p == 2'b01) begin
                e_vec[e_n] = {1'b1, 3'd1, 4'(i), 79'd0, p[0], b[32+16*i +: 16]};
                e_tag[e_n] = p[0] ? "R4" : "R3";
                e_n++;
                i++;
            end else if (p == 2'b10) begin
                int r;
                logic [95:0] d;
                r = 0;
                while (r < 5 && (i + 1 + r) < 14 && b[2*(i+1+r) +: 2] == 2'b11) r++;
                if (r == 0) begin
                    e_err = 1'b1;
                    i++;
                end else begin
                    d = '0;
                    for (int k = 0; k <= r; k++) d[95-16*k -: 16] = b[32+16*(i+k) +: 16];
                    e_vec[e_n] = {1'b0, 3'(r+1), 4'(i), d};
                    e_tag[e_n] = (r == 5) ? "R6" : "R5";
                    e_n++;
                    i += r + 1;
                end
            end else begin
                i++;
            end
        end
    endtask

    task automatic run_block(input logic [255:0] b, input int ready_pct);
        int got;
        int cyc;
        bit stalled;
        logic [103:0] held, cur;
        model(b);
        while (!load_ready) @(negedge clk);
        load_valid = 1'b1;
        load_data  = b;
        @(negedge clk);
        load_valid = 1'b0;
        got = 0;
        cyc = 0;
        stalled = 1'b0;
        while (!done && cyc < 400) begin
            cur = {ins_short, ins_len, ins_off, ins_data};
            if (stalled) check(ins_valid && cur == held, "R9 hold", cur, held);
            ins_ready = ((rnd() % 100) < 32'(ready_pct));
            stalled = 1'b0;
            if (ins_valid) begin
                if (ins_ready) begin
                    if (got < e_n) check(cur == e_vec[got], e_tag[got], cur, e_vec[got]);
                    else check(1'b0, "R7 extra output", cur, '0);
                    got++;
                end else begin
                    stalled = 1'b1;
                    held = cur;
                end
            end
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, "R10 done", 104'(done), 104'd1);
        check(got == e_n, "R7 R8 count", 104'(got), 104'(e_n));
        check(err == e_err, (b[31:28] != 4'hF) ? "R2 err" : "R8 err", 104'(err), 104'(e_err));
        check(load_ready == 1'b1, "R10 load_ready", 104'(load_ready), 104'd1);
    endtask

    function automatic logic [255:0] mk(input logic [3:0] form,
                                        input logic [13:0][1:0] pl, input int base);
        logic [255:0] b;
        b[31:28] = form;
        b[27:0]  = pl;
        for (int k = 0; k < 14; k++) b[32+16*k +: 16] = 16'(base + 16'h1111 * k);
        return b;
    endfunction

    initial begin
        logic [13:0][1:0] pl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({ins_valid, done, err, load_ready} == 4'b0001, "R1 reset",
              104'({ins_valid, done, err, load_ready}), 104'b0001);

        for (int k = 0; k < 14; k++) pl[k] = 2'b00;
        run_block(mk(4'hF, pl, 16'h0123), 100);
        for (int k = 0; k < 14; k++) pl[k] = 2'b01;
        run_block(mk(4'hF, pl, 16'h8421), 50);

        pl[0] = 2'b10; pl[1] = 2'b11;
        pl[2] = 2'b10;
        for (int k = 3; k <= 9; k++) pl[k] = 2'b11;
        pl[10] = 2'b00; pl[11] = 2'b01; pl[12] = 2'b10; pl[13] = 2'b11;
        run_block(mk(4'hF, pl, 16'h5A5A), 60);

        pl[0] = 2'b11; pl[1] = 2'b11; pl[2] = 2'b10; pl[3] = 2'b00;
        pl[4] = 2'b10; pl[5] = 2'b11; pl[6] = 2'b11; pl[7] = 2'b01;
        pl[8] = 2'b10; pl[9] = 2'b11; pl[10] = 2'b11; pl[11] = 2'b11;
        pl[12] = 2'b00; pl[13] = 2'b10;
        run_block(mk(4'hF, pl, 16'h3C00), 40);

        pl[0] = 2'b10;
        for (int k = 1; k <= 4; k++) pl[k] = 2'b11;
        for (int k = 5; k < 14; k++) pl[k] = 2'b01;
        run_block(mk(4'hF, pl, 16'hBEEF), 100);

        run_block(mk(4'hE, pl, 16'h0F0F), 100);
        run_block(mk(4'h7, pl, 16'h1F1F), 30);

        for (int n = 0; n < 300; n++) begin
            logic [255:0] b;
            for (int w = 0; w < 8; w++) b[32*w +: 32] = rnd();
            if (n % 10 != 0) b[31:28] = 4'hF;
            run_block(b, (n % 3 == 0) ? 100 : 55);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule